// File: doc/BRIEF.md
# Multi-Mode Serial Line Encoder

This block turns a stream of data bits into line symbols for a serial link, one bit per bit cell. A single code is chosen per cell from six line codes: plain level, transition-on-one, return-to-zero, alternating-polarity return-to-zero, split-phase (Manchester) and three-level cyclic (MLT-3). Each bit cell is split into two half-cells. The block therefore runs on a clock at twice the bit rate, and a phase input marks which half-cell each edge begins.

At the edge that opens a cell, the block captures the data bit, its valid flag and the code select. It then drives the first-half symbol, holds the second-half symbol and advances the running state of the selected code. That state is the line level for the transition code, the next pulse polarity for the alternating code, and the step position for the three-level code. The output is a two-bit signed level, so the codes that need a negative level can drive one.

Top module: `serial_line_encoder`

## Requirements
- R1: A rising edge with `phase_i`=0 opens a cell and captures `bit_i`, `bit_vld_i` and `mode_i`. The first-half symbol appears on `line_o` after that edge, and the second-half symbol after the next edge, which has `phase_i`=1. Input changes during the second half do not affect that cell. Mode codes: 0 level, 1 transition, 2 return-to-zero, 3 alternating pulse, 4 split-phase, 5 three-level, 6 and 7 reserved.
- R2: `line_o` is two's complement: 01 is +1, 00 is 0, 11 is −1. In mode 0 both halves carry +1 for a 1 and 0 for a 0.
- R3: In mode 1, a 1 inverts the held level (0 or +1) at the start of the cell and a 0 keeps it. Both halves show the resulting level.
- R4: In mode 2, a 1 gives +1 in the first half and 0 in the second half. A 0 gives 0 in both halves.
- R5: In mode 3, 1s give pulses in the first half whose sign alternates, starting at +1 after reset. The second half is 0, and 0 bits give 0 in both halves.
- R6: In mode 4, a 1 gives +1 then 0, and a 0 gives 0 then +1. The level therefore changes at mid-cell in every valid cell.
- R7: In mode 5, each 1 advances the level one step through the cycle 0, +1, 0, −1, and a 0 holds it. Both halves show the level.
- R8: Reset drives `line_o` to 0, clears the transition level to 0, sets the next alternating pulse to +1, and puts the three-level code at 0 with +1 as its next step.
- R9: A cell opened with `bit_vld_i`=0 advances no state. Modes 1 and 5 show their held level in both halves, and all other modes show 0.
- R10: A cell in mode 6 or 7 drives 0 in both halves and advances no state.
- R11: Each code's state advances only in cells that select that code, so it is kept unchanged while other modes are in use.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-cell clock, twice the bit rate |
| rst | input | 1 | Synchronous active-high reset |
| phase_i | input | 1 | 0 on the edge that opens a cell, 1 on the mid-cell edge |
| bit_i | input | 1 | Data bit for the cell |
| bit_vld_i | input | 1 | Data bit is present for this cell |
| mode_i | input | 3 | Line code select |
| line_o | output | 2 | Signed line level |

## Verification
The hardest situations to reach are those where one code's stored state must survive while other codes are in use, and where inputs move during the second half of a cell. The stimulus runs the same ten-bit pattern through every mode in turn without a reset in between. It then interleaves the three-level and alternating-pulse modes, so that their saved positions are exercised. During every second half-cell it drives an inverted bit, an inverted valid flag and a different mode, so any late sampling of the inputs shows up as a wrong symbol.

// File: rtl/lnenc_pkg.sv
package lnenc_pkg;

    localparam int LVL_W     = 2;
    localparam int MODE_W    = 3;
    localparam int MLT_STEPS = 4;
    localparam int MLT_W     = $clog2(MLT_STEPS);

    typedef logic signed [LVL_W-1:0] lvl_t;

    localparam lvl_t LVL_ZERO = 2'sb00;
    localparam lvl_t LVL_POS  = 2'sb01;
    localparam lvl_t LVL_NEG  = 2'sb11;

    typedef enum logic [MODE_W-1:0] {
        M_NRZ   = 3'd0,
        M_NRZI  = 3'd1,
        M_RZ    = 3'd2,
        M_BPRZ  = 3'd3,
        M_MANCH = 3'd4,
        M_MLT3  = 3'd5
    } mode_e;

    typedef struct packed {
        logic             nrzi_hi;
        logic             bp_neg;
        logic [MLT_W-1:0] mlt_idx;
    } code_state_t;

    typedef struct packed {
        lvl_t first;
        lvl_t second;
    } sym_pair_t;

    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic              vld;
    } cell_ctx_t;

    function automatic lvl_t lvl_of_bit(input logic b);
        return b ? LVL_POS : LVL_ZERO;
    endfunction

    function automatic lvl_t mlt_level(input logic [MLT_W-1:0] idx);
        lvl_t r;
        case (idx)
            2'd0:    r = LVL_ZERO;
            2'd1:    r = LVL_POS;
            2'd2:    r = LVL_ZERO;
            default: r = LVL_NEG;
        endcase
        return r;
    endfunction

    function automatic lvl_t pulse_level(input logic neg);
        return neg ? LVL_NEG : LVL_POS;
    endfunction

endpackage

// File: rtl/lnenc_state.sv
module lnenc_state
    import lnenc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cell_go,
    input  logic              vld,
    input  logic              bit_in,
    input  logic [MODE_W-1:0] mode,
    output code_state_t       st_q,
    output code_state_t       st_nxt
);

    always_comb begin
        st_nxt = st_q;
        if (vld) begin
            case (mode)
                M_NRZI: st_nxt.nrzi_hi = st_q.nrzi_hi ^ bit_in;
                M_BPRZ: st_nxt.bp_neg  = st_q.bp_neg ^ bit_in;
                M_MLT3: if (bit_in) st_nxt.mlt_idx = st_q.mlt_idx + MLT_W'(1);
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else if (cell_go) begin
            st_q <= st_nxt;
        end
    end

    // R5: each 1 in alternating mode flips the next pulse sign
    assert_pulse_flip_R5: assert property (@(posedge clk) disable iff (rst)
        (cell_go && vld && bit_in && mode == M_BPRZ) |=> (st_q.bp_neg != $past(st_q.bp_neg)));

    // R7, R11: three-level step moves only on a valid 1 in its own mode
    assert_mlt_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !(cell_go && vld && bit_in && mode == M_MLT3) |=> $stable(st_q.mlt_idx));

    // R3, R9: transition level kept unless a valid 1 arrives in its mode
    assert_nrzi_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !(cell_go && vld && bit_in && mode == M_NRZI) |=> $stable(st_q.nrzi_hi));

endmodule

// File: rtl/lnenc_symbol.sv
module lnenc_symbol
    import lnenc_pkg::*;
(
    input  logic              vld,
    input  logic              bit_in,
    input  logic [MODE_W-1:0] mode,
    input  code_state_t       st_q,
    input  code_state_t       st_nxt,
    output sym_pair_t         sym
);

    always_comb begin
        sym.first  = LVL_ZERO;
        sym.second = LVL_ZERO;
        if (!vld) begin
            case (mode)
                M_NRZI: begin
                    sym.first  = lvl_of_bit(st_q.nrzi_hi);
                    sym.second = lvl_of_bit(st_q.nrzi_hi);
                end
                M_MLT3: begin
                    sym.first  = mlt_level(st_q.mlt_idx);
                    sym.second = mlt_level(st_q.mlt_idx);
                end
                default: ;
            endcase
        end else begin
            case (mode)
                M_NRZ: begin
                    sym.first  = lvl_of_bit(bit_in);
                    sym.second = lvl_of_bit(bit_in);
                end
                M_NRZI: begin
                    sym.first  = lvl_of_bit(st_nxt.nrzi_hi);
                    sym.second = lvl_of_bit(st_nxt.nrzi_hi);
                end
                M_RZ: begin
                    sym.first  = lvl_of_bit(bit_in);
                end
                M_BPRZ: begin
                    if (bit_in) sym.first = pulse_level(st_q.bp_neg);
                end
                M_MANCH: begin
                    sym.first  = lvl_of_bit(bit_in);
                    sym.second = lvl_of_bit(!bit_in);
                end
                M_MLT3: begin
                    sym.first  = mlt_level(st_nxt.mlt_idx);
                    sym.second = mlt_level(st_nxt.mlt_idx);
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/lnenc_out.sv
module lnenc_out
    import lnenc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      cell_go,
    input  sym_pair_t sym,
    input  cell_ctx_t ctx,
    output lvl_t      line_q
);

    lvl_t      hold_q;
    cell_ctx_t ctx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            line_q <= LVL_ZERO;
            hold_q <= LVL_ZERO;
            ctx_q  <= '0;
        end else if (cell_go) begin
            line_q <= sym.first;
            hold_q <= sym.second;
            ctx_q  <= ctx;
        end else begin
            line_q <= hold_q;
        end
    end

    // R4: second half of a return-to-zero cell is zero
    assert_rz_return_R4: assert property (@(posedge clk) disable iff (rst)
        (!cell_go && ctx_q.vld && ctx_q.mode == M_RZ) |=> (line_q == LVL_ZERO));

    // R6: split-phase cells always change level at mid-cell
    assert_manch_mid_R6: assert property (@(posedge clk) disable iff (rst)
        (!cell_go && ctx_q.vld && ctx_q.mode == M_MANCH) |=> (line_q != $past(line_q)));

    // R2: plain level code holds over the whole cell
    assert_nrz_flat_R2: assert property (@(posedge clk) disable iff (rst)
        (!cell_go && ctx_q.vld && ctx_q.mode == M_NRZ) |=> $stable(line_q));

    // R10: reserved modes produce zero at mid-cell
    assert_reserved_zero_R10: assert property (@(posedge clk) disable iff (rst)
        (!cell_go && ctx_q.mode > M_MLT3) |=> (line_q == LVL_ZERO));

endmodule

// File: rtl/serial_line_encoder.sv
module serial_line_encoder
    import lnenc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              phase_i,
    input  logic              bit_i,
    input  logic              bit_vld_i,
    input  logic [MODE_W-1:0] mode_i,
    output logic [LVL_W-1:0]  line_o
);

    logic        cell_go;
    code_state_t st_q;
    code_state_t st_nxt;
    sym_pair_t   sym;
    cell_ctx_t   ctx;
    lvl_t        line_q;

    assign cell_go  = !phase_i;
    assign ctx.mode = mode_i;
    assign ctx.vld  = bit_vld_i;

    lnenc_state u_state (
        .clk     (clk),
        .rst     (rst),
        .cell_go (cell_go),
        .vld     (bit_vld_i),
        .bit_in  (bit_i),
        .mode    (mode_i),
        .st_q    (st_q),
        .st_nxt  (st_nxt)
    );

    lnenc_symbol u_symbol (
        .vld     (bit_vld_i),
        .bit_in  (bit_i),
        .mode    (mode_i),
        .st_q    (st_q),
        .st_nxt  (st_nxt),
        .sym     (sym)
    );

    lnenc_out u_out (
        .clk     (clk),
        .rst     (rst),
        .cell_go (cell_go),
        .sym     (sym),
        .ctx     (ctx),
        .line_q  (line_q)
    );

    assign line_o = line_q;

    // R2: the output never takes the unused code 10
    assert_level_legal_R2: assert property (@(posedge clk) disable iff (rst)
        line_o != 2'b10);

endmodule

// File: tb/serial_line_encoder_tb.sv
module serial_line_encoder_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       phase_i = 1'b0;
    logic       bit_i = 1'b0;
    logic       bit_vld_i = 1'b0;
    logic [2:0] mode_i = 3'd0;
    logic [1:0] line_o;

    int n_cmp = 0;
    int n_bad = 0;

    typedef struct {
        logic [1:0] exp;
        string      tag;
    } item_t;

    item_t sb_q[$];

    // reference state
    logic   m_lvl;
    logic   m_neg;
    int     m_step;

    always #2 clk = ~clk;

    serial_line_encoder u_dut (
        .clk       (clk),
        .rst       (rst),
        .phase_i   (phase_i),
        .bit_i     (bit_i),
        .bit_vld_i (bit_vld_i),
        .mode_i    (mode_i),
        .line_o    (line_o)
    );

    function automatic logic [1:0] three_lvl(input int s);
        case (s)
            1:       return 2'b01;
            3:       return 2'b11;
            default: return 2'b00;
        endcase
    endfunction

    task automatic check(input logic [1:0] act, input logic [1:0] exp, input string tag);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: line_o=%b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    // reference model of one cell
    task automatic model(input logic [2:0] m, input logic b, input logic v,
                         output logic [1:0] f, output logic [1:0] s);
        f = 2'b00;
        s = 2'b00;
        if (!v) begin
            if (m == 3'd1) begin f = {1'b0, m_lvl}; s = f; end
            if (m == 3'd5) begin f = three_lvl(m_step); s = f; end
        end else begin
            case (m)
                3'd0: begin f = {1'b0, b}; s = f; end
                3'd1: begin m_lvl = m_lvl ^ b; f = {1'b0, m_lvl}; s = f; end
                3'd2: begin f = {1'b0, b}; end
                3'd3: begin
                    if (b) begin
                        f = m_neg ? 2'b11 : 2'b01;
                        m_neg = !m_neg;
                    end
                end
                3'd4: begin f = {1'b0, b}; s = {1'b0, !b}; end
                3'd5: begin
                    if (b) m_step = (m_step + 1) % 4;
                    f = three_lvl(m_step);
                    s = f;
                end
                default: ;
            endcase
        end
    endtask

    function automatic string mode_tag(input logic [2:0] m);
        case (m)
            3'd0: return "R2";
            3'd1: return "R3";
            3'd2: return "R4";
            3'd3: return "R5";
            3'd4: return "R6";
            3'd5: return "R7";
            default: return "R10";
        endcase
    endfunction

    // driver: one full cell; second half scrambles the inputs (R1)
    task automatic drive_cell(input logic [2:0] m, input logic b, input logic v, input string tag);
        logic [1:0] f;
        logic [1:0] s;
        item_t it;
        model(m, b, v, f, s);
        @(negedge clk);
        phase_i   = 1'b0;
        mode_i    = m;
        bit_i     = b;
        bit_vld_i = v;
        it.exp = f; it.tag = tag;
        sb_q.push_back(it);
        @(negedge clk);
        phase_i   = 1'b1;
        mode_i    = m + 3'd3;
        bit_i     = !b;
        bit_vld_i = !v;
        it.exp = s; it.tag = {tag, "/R1"};
        sb_q.push_back(it);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        phase_i = 1'b1;
        repeat (2) @(negedge clk);
        m_lvl = 1'b0; m_neg = 1'b0; m_step = 0;
        check(line_o, 2'b00, "R8 reset level");
        rst = 1'b0;
    endtask

    // monitor
    always @(posedge clk) begin
        #1;
        if (sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            check(line_o, it.exp, it.tag);
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    localparam logic [9:0] PATTERN = 10'b0011010111;

    initial begin
        m_lvl = 1'b0; m_neg = 1'b0; m_step = 0;
        do_reset();

        // the pattern in every mode, state carried across (R2..R7, R11)
        for (int m = 0; m < 6; m++) begin
            for (int i = 9; i >= 0; i--) begin
                drive_cell(3'(m), PATTERN[i], 1'b1, mode_tag(3'(m)));
            end
        end

        // idle cells in each mode (R9)
        for (int m = 0; m < 6; m++) begin
            drive_cell(3'(m), 1'b1, 1'b0, "R9 idle");
            drive_cell(3'(m), 1'b0, 1'b0, "R9 idle");
        end

        // reserved modes, then proof that no state moved (R10)
        drive_cell(3'd6, 1'b1, 1'b1, "R10");
        drive_cell(3'd7, 1'b1, 1'b1, "R10");
        drive_cell(3'd5, 1'b0, 1'b1, "R10 mlt kept");
        drive_cell(3'd1, 1'b0, 1'b1, "R10 nrzi kept");
        drive_cell(3'd3, 1'b1, 1'b1, "R10 pulse kept");

        // interleaved state (R11)
        drive_cell(3'd5, 1'b1, 1'b1, "R11");
        drive_cell(3'd3, 1'b1, 1'b1, "R11");
        drive_cell(3'd1, 1'b1, 1'b1, "R11");
        drive_cell(3'd5, 1'b1, 1'b1, "R11");
        drive_cell(3'd3, 1'b1, 1'b1, "R11");
        drive_cell(3'd0, 1'b1, 1'b1, "R11");
        drive_cell(3'd5, 1'b1, 1'b1, "R11");
        drive_cell(3'd1, 1'b1, 1'b1, "R11");

        // reset mid-stream, then first 1 in each stateful code (R8)
        repeat (2) @(negedge clk);
        do_reset();
        drive_cell(3'd1, 1'b1, 1'b1, "R8 nrzi start");
        drive_cell(3'd3, 1'b1, 1'b1, "R8 pulse start");
        drive_cell(3'd5, 1'b1, 1'b1, "R8 mlt start");

        repeat (4) @(negedge clk);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule